// File: doc/BRIEF.md
# Multiply and Power-of-Two Shift Unit

This block is the multiply datapath of a small 8-bit processor core. One 8×8 multiplier serves five operations. Two are multiplies: one treats both operands as unsigned and the other treats them as two's-complement. The other three are shifts by a 3-bit immediate: left, logical right and arithmetic right. Each shift is carried out as a multiplication of the destination operand by a power of two.

The 16-bit product is split into two bytes:
- The low byte goes to the accumulator.
- The high byte goes back to the destination register.

A right shift therefore leaves the shifted value in the destination byte. The bits that fall off the bottom appear left-aligned in the accumulator byte.

These operations leave the arithmetic flags undefined. The unit raises a keep-flags indication with every result so that the flag logic next to it makes no update. Operand fetch and the register file belong to the surrounding core. A valid/ready handshake captures one operation per cycle. When the optional output register is present, both result bytes appear in the following cycle.

Top module: `mshift_unit`

## Requirements
- R1: Opcode 0 (unsigned multiply) gives {out_dst, out_acc} = in_dst × in_src, with both operands treated as unsigned.
- R2: Opcode 1 (signed multiply) gives {out_dst, out_acc} = the low 16 bits of the two's-complement product of in_dst and in_src.
- R3: Opcode 2 (shift left) gives {out_dst, out_acc} = in_dst × 2^in_shamt. So out_dst holds the bits shifted out of the top and out_acc holds in_dst << in_shamt.
- R4: Opcode 3 (logical shift right) gives {out_dst, out_acc} = in_dst × 2^(8−in_shamt). out_dst = in_dst >> in_shamt, and out_acc holds the dropped bits left-aligned. When in_shamt is 0, out_dst = in_dst and out_acc = 0x00.
- R5: Opcode 4 (arithmetic shift right) is like R4, but in_dst is first sign-extended to 16 bits. out_dst is then filled from bit 7.
- R6: For opcodes 2, 3 and 4 the value on in_src has no effect on either result byte.
- R7: out_flags_keep is high exactly when out_valid is high.
- R8: An operation is taken when in_valid and in_ready are both high at a clock edge. Its result is shown with out_valid high after that edge. out_valid falls after a cycle in which the result is taken and nothing new is accepted.
- R9: While out_valid is high and out_ready is low, in_ready is low, and out_valid, out_dst and out_acc hold their values.
- R10: Synchronous active-high reset clears out_valid, out_dst and out_acc to 0 and leaves in_ready high.
- R11: Opcodes 5, 6 and 7 behave as the unsigned multiply of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 3 | Operation code (0 unsigned mul, 1 signed mul, 2 shift left, 3 shift right, 4 arithmetic shift right) |
| in_dst | input | 8 | Destination register operand |
| in_src | input | 8 | Second multiply operand |
| in_shamt | input | 3 | Shift amount, 0 to 7 |
| out_valid | output | 1 | Result bytes are valid |
| out_ready | input | 1 | Consumer takes the result |
| out_acc | output | 8 | Low product byte, for the accumulator |
| out_dst | output | 8 | High product byte, for the destination register |
| out_flags_keep | output | 1 | Flags must not be updated by this result |

## Verification
The assertions check the product against an independent shift or native-arithmetic expression on every cycle, for every opcode. They also check the handshake on every cycle: acceptance leads to valid, a stall holds the result steady, and a drain with no new request clears valid. Only the bench's scenarios can show the following. All 65,536 operand pairs of both multiplies give the right bytes. The shift results ignore the second operand. Undefined opcodes fall back to the unsigned multiply. A request offered during a stall is neither lost nor duplicated once the stall lifts.

// File: rtl/mshift_pkg.sv
package mshift_pkg;

    localparam int DATA_W  = 8;
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int OP_W    = 3;
    localparam int PROD_W  = 2 * DATA_W;

    typedef enum logic [OP_W-1:0] {
        OP_MULU = 3'd0,
        OP_MULS = 3'd1,
        OP_SHL  = 3'd2,
        OP_SHR  = 3'd3,
        OP_SHRA = 3'd4
    } op_e;

    // Multiplicand must be sign-extended for these codes
    function automatic logic needs_sext(input op_e op);
        return (op == OP_MULS) || (op == OP_SHRA);
    endfunction

    function automatic logic is_right_shift(input op_e op);
        return (op == OP_SHR) || (op == OP_SHRA);
    endfunction

endpackage

// File: rtl/mshift_operand_former.sv
module mshift_operand_former
    import mshift_pkg::*;
#(
    parameter int W  = DATA_W,
    localparam int SW = $clog2(W)
) (
    input  op_e            op,
    input  logic [W-1:0]   dst_v,
    input  logic [W-1:0]   src_v,
    input  logic [SW-1:0]  shamt,
    output logic [2*W-1:0] mcand,
    output logic [2*W-1:0] mplier
);

    always_comb begin
        if (needs_sext(op)) begin
            mcand = {{W{dst_v[W-1]}}, dst_v};
        end else begin
            mcand = {{W{1'b0}}, dst_v};
        end

        mplier = '0;
        case (op)
            OP_MULS: mplier = {{W{src_v[W-1]}}, src_v};
            OP_SHL:  mplier[shamt] = 1'b1;
            OP_SHR,
            OP_SHRA: mplier[W - int'(shamt)] = 1'b1;
            default: mplier = {{W{1'b0}}, src_v};
        endcase
    end

    // Shift weight must be a single power of two
    always_comb begin
        if (op == OP_SHL || is_right_shift(op)) begin
            // R6
            weight_onehot_chk: assert ($countones(mplier) == 1);
        end
    end

endmodule

// File: rtl/mshift_mult_core.sv
module mshift_mult_core
    import mshift_pkg::*;
#(
    parameter int W  = DATA_W,
    localparam int SW = $clog2(W),
    localparam int PW = 2 * W
) (
    input  logic [PW-1:0] mcand,
    input  logic [PW-1:0] mplier,
    input  op_e           op,
    input  logic [W-1:0]  dst_v,
    input  logic [W-1:0]  src_v,
    input  logic [SW-1:0] shamt,
    output logic [W-1:0]  hi,
    output logic [W-1:0]  lo
);

    logic [PW-1:0] prod;

    assign prod     = mcand * mplier;
    assign {hi, lo} = prod;

    logic signed [PW-1:0] sra_ref;
    logic signed [PW-1:0] smul_ref;
    logic        [PW-1:0] umul_ref;

    always_comb begin
        sra_ref  = $signed({dst_v, {W{1'b0}}}) >>> shamt;
        smul_ref = PW'($signed(dst_v) * $signed(src_v));
        umul_ref = PW'(dst_v) * PW'(src_v);
        case (op)
            OP_MULS: begin
                // R2
                smul_chk: assert (prod == smul_ref);
            end
            OP_SHL: begin
                // R3
                shl_chk: assert (prod == ({{W{1'b0}}, dst_v} << shamt));
            end
            OP_SHR: begin
                // R4
                shr_chk: assert (prod == ({dst_v, {W{1'b0}}} >> shamt));
            end
            OP_SHRA: begin
                // R5
                shra_chk: assert (prod == sra_ref);
            end
            default: begin
                // R1
                umul_chk: assert (prod == umul_ref);
            end
        endcase
    end

endmodule

// File: rtl/mshift_out_stage.sv
module mshift_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] hi_d,
    input  logic [W-1:0] lo_d,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q
);

    logic v_q;

    assign in_ready  = !v_q || out_ready;
    assign out_valid = v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q  <= 1'b0;
            hi_q <= '0;
            lo_q <= '0;
        end else if (in_ready) begin
            v_q <= in_valid;
            if (in_valid) begin
                hi_q <= hi_d;
                lo_q <= lo_d;
            end
        end
    end

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && hi_q == '0 && lo_q == '0));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R8
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(hi_q) && $stable(lo_q)));

    // R9
    stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/mshift_unit.sv
module mshift_unit
    import mshift_pkg::*;
#(
    parameter int W       = DATA_W,
    parameter bit REG_OUT = 1'b1,
    localparam int SW     = $clog2(W),
    localparam int PW     = 2 * W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    in_op,
    input  logic [W-1:0]  in_dst,
    input  logic [W-1:0]  in_src,
    input  logic [SW-1:0] in_shamt,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_acc,
    output logic [W-1:0]  out_dst,
    output logic          out_flags_keep
);

    op_e           op;
    logic [PW-1:0] mcand;
    logic [PW-1:0] mplier;
    logic [W-1:0]  prod_hi;
    logic [W-1:0]  prod_lo;

    assign op = op_e'(in_op);

    mshift_operand_former #(.W(W)) u_former (
        .op     (op),
        .dst_v  (in_dst),
        .src_v  (in_src),
        .shamt  (in_shamt),
        .mcand  (mcand),
        .mplier (mplier)
    );

    mshift_mult_core #(.W(W)) u_core (
        .mcand  (mcand),
        .mplier (mplier),
        .op     (op),
        .dst_v  (in_dst),
        .src_v  (in_src),
        .shamt  (in_shamt),
        .hi     (prod_hi),
        .lo     (prod_lo)
    );

    generate
        if (REG_OUT) begin : g_reg
            mshift_out_stage #(.W(W)) u_stage (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (in_valid),
                .in_ready  (in_ready),
                .hi_d      (prod_hi),
                .lo_d      (prod_lo),
                .out_valid (out_valid),
                .out_ready (out_ready),
                .hi_q      (out_dst),
                .lo_q      (out_acc)
            );
        end else begin : g_comb
            assign in_ready  = out_ready;
            assign out_valid = in_valid;
            assign out_dst   = prod_hi;
            assign out_acc   = prod_lo;
        end
    endgenerate

    // Flags are never written by these operations
    assign out_flags_keep = out_valid;

    // R7
    flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_flags_keep);

endmodule

// File: tb/mshift_unit_bench.sv
module mshift_unit_bench;

    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic [2:0] in_op;
    logic [7:0] in_dst;
    logic [7:0] in_src;
    logic [2:0] in_shamt;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_acc;
    logic [7:0] out_dst;
    logic       out_flags_keep;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic        pend;
    logic [15:0] pend_exp;
    string       pend_req;

    always #2 clk = ~clk;

    mshift_unit u_mshift_unit (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_op          (in_op),
        .in_dst         (in_dst),
        .in_src         (in_src),
        .in_shamt       (in_shamt),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_acc        (out_acc),
        .out_dst        (out_dst),
        .out_flags_keep (out_flags_keep)
    );

    function automatic logic [15:0] model(input int op, input int d, input int s, input int sh);
        int ds;
        int ss;
        int r;
        ds = (d >= 128) ? d - 256 : d;
        ss = (s >= 128) ? s - 256 : s;
        case (op)
            1:       r = ds * ss;
            2:       r = d * (1 << sh);
            3:       r = (d * 256) / (1 << sh);
            4:       r = (ds * 256) >>> sh;
            default: r = d * s;
        endcase
        return 16'(r);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // compare the result of the previous accepted operation
    task automatic check_pending();
        if (pend) begin
            check({pend_req, " R7 R8"}, {14'd0, out_valid, out_flags_keep}, 32'd3);
            check(pend_req, {16'd0, out_dst, out_acc}, {16'd0, pend_exp});
            pend = 1'b0;
        end
    endtask

    task automatic send(input int op, input int d, input int s, input int sh, input string req);
        @(negedge clk);
        check_pending();
        in_valid = 1'b1;
        in_op    = 3'(op);
        in_dst   = 8'(d);
        in_src   = 8'(s);
        in_shamt = 3'(sh);
        pend     = 1'b1;
        pend_exp = model(op, d, s, sh);
        pend_req = req;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; pend = 1'b0;
        in_op = '0; in_dst = '0; in_src = '0; in_shamt = '0;
        pend_exp = '0; pend_req = "";
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state, R7 flags idle
        check("R10", {28'd0, out_valid, in_ready, out_flags_keep, 1'b0}, {28'd0, 4'b0100});
        check("R10", {16'd0, out_dst, out_acc}, 32'd0);
        rst = 1'b0;

        // R1 exhaustive unsigned multiply
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 256; s++)
                send(0, d, s, 0, "R1");
        // R2 exhaustive signed multiply
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 256; s++)
                send(1, d, s, 0, "R2");
        // R3 R4 R5 with varying second operand for R6
        for (int sh = 0; sh < 8; sh++)
            for (int d = 0; d < 256; d++) begin
                send(2, d, (d * 37 + sh * 91) & 255, sh, "R3 R6");
                send(3, d, (d ^ 8'hA5) & 255, sh, "R4 R6");
                send(4, d, (255 - d + sh) & 255, sh, "R5 R6");
            end
        // R4 zero shift corner: value unchanged, accumulator cleared
        send(3, 8'hB7, 8'hFF, 0, "R4");
        send(4, 8'h80, 8'h00, 0, "R5");
        // R11 undefined codes fall back to unsigned multiply
        for (int op = 5; op < 8; op++)
            for (int d = 0; d < 256; d += 7)
                for (int s = 0; s < 256; s += 11)
                    send(op, d, s, 0, "R11");

        @(negedge clk);
        check_pending();
        in_valid = 1'b0;
        @(negedge clk);
        // R8 drain, R7 flag indication drops with valid
        check("R8 R7", {30'd0, out_valid, out_flags_keep}, 32'd0);

        // R9 stall
        out_ready = 1'b0;
        in_valid = 1'b1; in_op = 3'd0; in_dst = 8'd12; in_src = 8'd13;
        @(negedge clk);
        check("R9", {15'd0, out_valid, out_dst, out_acc}, {15'd0, 1'b1, 16'd156});
        check("R9", {31'd0, in_ready}, 32'd0);
        in_dst = 8'd200; in_src = 8'd200;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9", {15'd0, out_valid, out_dst, out_acc}, {15'd0, 1'b1, 16'd156});
            check("R9", {31'd0, in_ready}, 32'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        check("R9 R8", {15'd0, out_valid, out_dst, out_acc}, {15'd0, 1'b1, 16'd40000});
        in_valid = 1'b0;
        @(negedge clk);
        check("R8", {31'd0, out_valid}, 32'd0);

        finished = 1'b1;
        finish_run();
    end

endmodule